// File: doc/BRIEF.md
# Branch Clock Gate Controller

This block holds the on/off and divide settings for a group of branch clocks that all come from one base clock. Each branch has a single configuration word behind a small memory-mapped register port. The block turns each word into a registered clock-enable strobe for that branch. Downstream logic uses the strobe as a clock enable, so the whole design stays in one clock domain and no clock is gated.

A branch runs when its run bit is set. Setting the auto bit lets the branch pause while its bus is idle. Shutting a branch down safely takes two writes: the first arms auto, the second clears run. The enable then stays high until the branch's bus-idle input is seen high, which models a request/acknowledge wait.

Branches chosen by a build-time mask can divide by two. Their divider request bit is write-only, and a separate status bit reports the division actually in effect. Software must copy that status into the request on any read-modify-write. A change in division only takes effect on an even base-clock boundary, so the enable pattern never produces a short pulse.

Top module: `bcg_branch_gate`

## Requirements
- R1: While reset is asserted every enable output is 0. After reset the run bit (bit 0) reads 1 exactly for the branches in the `RUN_AT_RESET` mask. The auto bit and the divider status read 0 on every branch, and the branches in the mask drive their enable high from the first cycle after reset.
- R2: When a write sets run (bit 0) on a branch without divide-by-two, the enable output is high in every cycle that starts at the clock edge which takes the write.
- R3: Reading branch word N (address N) returns run on bit 0, auto on bit 1 and the divider status on bit 27. Every other bit reads 0, including the write-only divider request on bit 5.
- R4: After a write with run=0 and auto=1 on a running branch, the enable stays high until `bus_idle` is sampled high at a clock edge. From that edge on the enable is low, and it stays low after the bus is busy again.
- R5: A write that clears run while auto is also 0 does not stop a running branch: its enable stays high.
- R6: With run=1 and auto=1, the enable is low in the cycle after each edge at which `bus_idle` is sampled high, and high otherwise.
- R7: With the divider status set and the branch live, the enable is high only in the cycles after even-numbered clock edges. Edges are counted from 1 at the first edge after reset is released.
- R8: A write to bit 5 of a divider-capable branch updates the divider status at the first even-numbered edge at or after the edge that takes the write.
- R9: On a branch outside `DIV_MASK`, bit 5 is ignored. Its status stays 0 and its enable is never divided.
- R10: A read-modify-write that copies the status (bit 27) back into bit 5 leaves the divider status and the enable pattern unchanged.
- R11: Writes to an address at or above `NUM_BR` change no branch, and reads of such an address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | One-cycle write strobe |
| reg_addr | input | ADDR_W | Word index (branch number) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| bus_idle | input | NUM_BR | Per-branch bus-idle acknowledge |
| br_en | output | NUM_BR | Registered per-branch clock-enable strobe |

## Verification
The bench builds the block with `NUM_BR=5`, `DIV_MASK=5'b01010` and `RUN_AT_RESET=5'b00101`. Because 5 is not a power of two, the 3-bit address has three unmapped words, which brings the ignored-address case of R11 within reach. The mixed masks put capable and non-capable branches, and branches that start running or stopped, side by side. This lets one stimulus run check divided and undivided patterns, divider writes at both phase parities, and the safe and unsafe shutdown sequences, with the enable compared every cycle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int WORD_W   = 32;
    localparam int RUN_BIT  = 0;
    localparam int AUTO_BIT = 1;
    localparam int DREQ_BIT = 5;
    localparam int DSTA_BIT = 27;

    localparam logic [WORD_W-1:0] RD_MASK =
        (WORD_W'(1) << RUN_BIT) | (WORD_W'(1) << AUTO_BIT) | (WORD_W'(1) << DSTA_BIT);

    typedef struct packed {
        logic div_stat;
        logic div_req;
        logic auto_gate;
        logic run;
    } branch_cfg_t;

    function automatic logic [WORD_W-1:0] cfg_to_word(branch_cfg_t c);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[RUN_BIT]  = c.run;
        w[AUTO_BIT] = c.auto_gate;
        w[DSTA_BIT] = c.div_stat;
        return w;
    endfunction

endpackage

// File: rtl/bcg_phase.sv
module bcg_phase (
    input  logic clk,
    input  logic rst,
    output logic phase
);
    // phase is 1 after odd-numbered edges, 0 after even-numbered edges
    always_ff @(posedge clk) begin
        if (rst) phase <= 1'b0;
        else     phase <= ~phase;
    end
endmodule

// File: rtl/bcg_regport.sv
module bcg_regport
    import bcg_pkg::*;
#(
    parameter int NUM_BR = 8,
    parameter int ADDR_W = 3
) (
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  branch_cfg_t [NUM_BR-1:0] cfg,
    output logic [NUM_BR-1:0]        we_vec,
    output logic [WORD_W-1:0]        reg_rdata
);
    always_comb begin
        we_vec    = '0;
        reg_rdata = '0;
        for (int i = 0; i < NUM_BR; i++) begin
            if (reg_addr == ADDR_W'(i)) begin
                we_vec[i] = reg_we;
                reg_rdata = cfg_to_word(cfg[i]);
            end
        end
    end
endmodule

// File: rtl/bcg_branch.sv
module bcg_branch
    import bcg_pkg::*;
#(
    parameter bit DIV_CAP      = 1'b0,
    parameter bit RUN_AT_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              bus_idle,
    input  logic              phase,
    output branch_cfg_t       cfg,
    output logic              en
);
    logic unused_w;
    assign unused_w = ^wdata;

    branch_cfg_t cfg_n;
    logic        live, live_n, on_n;

    always_comb begin
        cfg_n.run       = we ? wdata[RUN_BIT]  : cfg.run;
        cfg_n.auto_gate = we ? wdata[AUTO_BIT] : cfg.auto_gate;
    end

    generate
        if (DIV_CAP) begin : g_div
            always_comb begin
                cfg_n.div_req  = we ? wdata[DREQ_BIT] : cfg.div_req;
                // status only moves on the edge that begins an even cycle
                cfg_n.div_stat = phase ? cfg_n.div_req : cfg.div_stat;
            end
        end else begin : g_nodiv
            always_comb begin
                cfg_n.div_req  = 1'b0;
                cfg_n.div_stat = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        if (cfg_n.run)                         live_n = 1'b1;
        else if (cfg_n.auto_gate && bus_idle)  live_n = 1'b0;
        else                                   live_n = live;
        on_n = live_n && !(cfg_n.run && cfg_n.auto_gate && bus_idle);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.run       <= RUN_AT_RESET;
            cfg.auto_gate <= 1'b0;
            cfg.div_req   <= 1'b0;
            cfg.div_stat  <= 1'b0;
            live          <= RUN_AT_RESET;
            en            <= 1'b0;
        end else begin
            cfg  <= cfg_n;
            live <= live_n;
            en   <= on_n && (!cfg_n.div_stat || phase);
        end
    end
endmodule

// File: rtl/bcg_branch_gate.sv
module bcg_branch_gate
    import bcg_pkg::*;
#(
    parameter int                NUM_BR       = 8,
    parameter logic [NUM_BR-1:0] DIV_MASK     = 8'hF0,
    parameter logic [NUM_BR-1:0] RUN_AT_RESET = 8'h03,
    localparam int               ADDR_W       = (NUM_BR > 1) ? $clog2(NUM_BR) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [NUM_BR-1:0] bus_idle,
    output logic [NUM_BR-1:0] br_en
);
    logic                     phase;
    logic [NUM_BR-1:0]        we_vec;
    logic [NUM_BR-1:0]        div_stat_vec;
    branch_cfg_t [NUM_BR-1:0] cfg;

    bcg_phase i_phase (.clk(clk), .rst(rst), .phase(phase));

    bcg_regport #(.NUM_BR(NUM_BR), .ADDR_W(ADDR_W)) i_regport (
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .cfg      (cfg),
        .we_vec   (we_vec),
        .reg_rdata(reg_rdata)
    );

    for (genvar i = 0; i < NUM_BR; i++) begin : g_br
        bcg_branch #(.DIV_CAP(DIV_MASK[i]), .RUN_AT_RESET(RUN_AT_RESET[i])) i_branch (
            .clk     (clk),
            .rst     (rst),
            .we      (we_vec[i]),
            .wdata   (reg_wdata),
            .bus_idle(bus_idle[i]),
            .phase   (phase),
            .cfg     (cfg[i]),
            .en      (br_en[i])
        );
        assign div_stat_vec[i] = cfg[i].div_stat;
    end
endmodule

// File: rtl/bcg_branch_gate_chk.sv
module bcg_branch_gate_chk
    import bcg_pkg::*;
#(
    parameter int                NUM_BR   = 8,
    parameter logic [NUM_BR-1:0] DIV_MASK = '0,
    parameter int                ADDR_W   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [WORD_W-1:0] reg_rdata,
    input logic [NUM_BR-1:0] br_en,
    input logic [NUM_BR-1:0] div_stat,
    input logic              phase
);
    function automatic logic cap_at(logic [ADDR_W-1:0] a);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_BR; i++)
            if (a == ADDR_W'(i)) r = DIV_MASK[i];
        return r;
    endfunction

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (br_en == '0));

    // R3
    rd_unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~RD_MASK) == '0);

    // R9
    nocap_stat_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_at(reg_addr) |-> (reg_rdata[DSTA_BIT] == 1'b0));

    for (genvar i = 0; i < NUM_BR; i++) begin : g_chk
        // R7
        div_alternate_chk: assert property (@(posedge clk) disable iff (rst)
            (div_stat[i] && br_en[i]) |=> !br_en[i]);
        // R8
        div_even_edge_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(div_stat[i]) |-> !phase);
    end
endmodule

bind bcg_branch_gate bcg_branch_gate_chk #(
    .NUM_BR(NUM_BR), .DIV_MASK(DIV_MASK), .ADDR_W(ADDR_W)
) i_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .br_en(br_en), .div_stat(div_stat_vec), .phase(phase)
);

// File: tb/test_bcg_branch_gate.sv
`timescale 1ns/1ps
module test_bcg_branch_gate;
    localparam int             NB   = 5;
    localparam int             AW   = 3;
    localparam logic [NB-1:0]  DIVM = 5'b01010;
    localparam logic [NB-1:0]  ESSM = 5'b00101;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NB-1:0] bus_idle = '0;
    logic [NB-1:0] br_en;

    always #2.5 clk = ~clk;

    bcg_branch_gate #(.NUM_BR(NB), .DIV_MASK(DIVM), .RUN_AT_RESET(ESSM)) i_bcg_branch_gate (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_idle(bus_idle), .br_en(br_en)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string tag    = "R1";

    // reference state derived from the requirements
    bit m_run[NB], m_auto[NB], m_req[NB], m_stat[NB], m_live[NB];
    bit m_p;
    logic [NB-1:0] exp_q[$];

    always @(posedge clk) begin
        logic [NB-1:0] e;
        e = '0;
        if (rst) begin
            for (int i = 0; i < NB; i++) begin
                m_run[i] = ESSM[i]; m_auto[i] = 0; m_req[i] = 0;
                m_stat[i] = 0; m_live[i] = ESSM[i];
            end
            m_p = 0;
        end else begin
            for (int i = 0; i < NB; i++) begin
                bit w, on;
                w = reg_we && (int'(reg_addr) == i);
                if (w) begin
                    m_run[i]  = reg_wdata[0];
                    m_auto[i] = reg_wdata[1];
                    if (DIVM[i]) m_req[i] = reg_wdata[5];
                end
                // even-numbered edge when the phase before it is 1
                if (DIVM[i] && m_p) m_stat[i] = m_req[i];
                if (m_run[i]) m_live[i] = 1;
                else if (m_auto[i] && bus_idle[i]) m_live[i] = 0;
                on = m_live[i] && !(m_run[i] && m_auto[i] && bus_idle[i]);
                e[i] = on && (!m_stat[i] || m_p);
            end
            m_p = ~m_p;
        end
        exp_q.push_back(e);
    end

    // monitor: compare every cycle away from the edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [NB-1:0] e;
            e = exp_q.pop_front();
            checks++;
            if (br_en !== e) begin
                fails++;
                $display("FAIL %s: br_en actual=%b expected=%b at %0t", tag, br_en, e, $time);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [31:0] model_word(int a);
        logic [31:0] w;
        w = '0;
        if (a < NB) begin
            w[0] = m_run[a]; w[1] = m_auto[a]; w[27] = m_stat[a];
        end
        return w;
    endfunction

    task automatic rd_chk(input int a, input logic [31:0] expv, input string r);
        @(negedge clk);
        reg_addr = AW'(a);
        #1;
        checks++;
        if (reg_rdata !== expv) begin
            fails++;
            $display("FAIL %s: rdata[%0d] actual=%h expected=%h", r, a, reg_rdata, expv);
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < NB; a++) rd_chk(a, {31'd0, ESSM[a]}, "R1");
        idle_cycles(3);

        tag = "R2";
        wr(1, 32'h1);
        rd_chk(1, 32'h1, "R2");
        idle_cycles(4);

        tag = "R9";
        wr(4, 32'hFFFF_FFFF);
        rd_chk(4, 32'h3, "R3");
        idle_cycles(4);
        rd_chk(4, 32'h3, "R9");
        wr(4, 32'h1);

        tag = "R8";
        wr(3, 32'h21);
        idle_cycles(1);
        rd_chk(3, model_word(3), "R8");
        tag = "R7";
        idle_cycles(8);
        rd_chk(3, 32'h0800_0001, "R7");
        rd_chk(3, 32'h0800_0001, "R3");

        tag = "R10";
        rd_chk(3, model_word(3), "R10");
        rv = reg_rdata;
        wr(3, (rv & 32'h3) | (rv[27] ? 32'h20 : 32'h0));
        rd_chk(3, 32'h0800_0001, "R10");
        idle_cycles(3);
        @(negedge clk);
        wr(3, (rv & 32'h3) | (rv[27] ? 32'h20 : 32'h0));
        rd_chk(3, 32'h0800_0001, "R10");
        idle_cycles(4);

        tag = "R8";
        wr(3, 32'h1);
        rd_chk(3, model_word(3), "R8");
        idle_cycles(3);
        rd_chk(3, 32'h1, "R8");
        @(negedge clk);
        wr(1, 32'h21);
        rd_chk(1, model_word(1), "R8");
        idle_cycles(6);

        tag = "R6";
        wr(2, 32'h3);
        idle_cycles(2);
        bus_idle[2] = 1'b1;
        idle_cycles(2);
        bus_idle[2] = 1'b0;
        idle_cycles(3);

        tag = "R5";
        wr(0, 32'h0);
        rd_chk(0, 32'h0, "R5");
        idle_cycles(5);

        tag = "R4";
        wr(1, 32'h23);
        wr(1, 32'h22);
        idle_cycles(4);
        bus_idle[1] = 1'b1;
        idle_cycles(1);
        bus_idle[1] = 1'b0;
        idle_cycles(4);
        wr(0, 32'h2);
        idle_cycles(2);
        bus_idle[0] = 1'b1;
        idle_cycles(2);
        bus_idle[0] = 1'b0;
        idle_cycles(3);

        tag = "R11";
        wr(6, 32'hFFFF_FFFF);
        wr(5, 32'h0);
        rd_chk(6, 32'h0, "R11");
        rd_chk(5, 32'h0, "R11");
        for (int a = 0; a < NB; a++) rd_chk(a, model_word(a), "R11");
        idle_cycles(4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule